// File: doc/BRIEF.md
# Serial Sensor Configuration Loader

This block programs the settings of a motion sensor that takes its configuration over a bit-serial two-wire link. It accepts a detection threshold, a gain selection and a filter-type selection through a valid/ready request. It packs them into a 48-bit settings image and drives the link clock. It shifts the image out on the data line, followed by a fixed end marker. After a settling pause it releases the data line and clocks the image back from the sensor. A last settling pause follows, and then the block compares what came back with what it sent.

The result is reported with one of three single-cycle pulses: success, readback mismatch, or budget overrun. The received image stays on an output bus. Every interval is counted in system clock cycles and derived from the `CLK_HZ` parameter: the serial half-period, the lead-in before the first clock, the two settling pauses and the overall budget.

Top module: `sensor_cfg_engine`

## Requirements
- R1: The settings image is 48 bits. The threshold occupies bits 17:10, the gain code bits 20:19 and the filter code bits 23:21. Every other bit is zero.
- R2: A gain value on `cfg_gain` of 2 gives code 3 and a value of 3 gives code 0. A value of 1 gives code 1, and a value of 0 also gives code 1. Filter selection 0, 1, 2 and 3 gives codes 7, 0, 1 and 2.
- R3: `sclk` idles low. Each serial bit spends HALF cycles low and then HALF cycles high, where HALF = CLK_HZ/2000 (at least 1).
- R4: The write sends 52 bits, least significant first. These are image bits 1 to 47 in rising order, then the marker bits 0,1,1,0,1 in that order. `sdat_oe` is high throughout the write, and `sdat_o` holds steady while `sclk` is high.
- R5: The readback clocks 48 bits with `sdat_oe` low. The block samples `sdat_i` in the last cycle of each high phase; the first bit received becomes bit 0 and later bits fill upward. Bit 0 is forced to zero, and the result appears on `rd_image`.
- R6: The first clock rise comes LEAD + HALF cycles after acceptance, where LEAD = CLK_HZ/100000 (at least 1). The first read rise comes GAP + HALF cycles after the last write fall, where GAP = 30·CLK_HZ/1000. The result pulse comes GAP cycles after the last read fall.
- R7: If `rd_image` equals the written image, `cfg_done` pulses. Otherwise `cfg_mismatch` pulses.
- R8: If the operation is still running BUDGET = BUDGET_MS·CLK_HZ/1000 cycles after acceptance, it aborts. `cfg_timeout` pulses, both link pins are released, and `cfg_ready` returns high in that same cycle.
- R9: `cfg_ready` is high only while the block is idle, and a request is taken only when `cfg_valid` and `cfg_ready` are both high. A `cfg_valid` seen while the block is busy starts nothing. The three result pulses last one cycle each and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Settings request valid |
| cfg_ready | output | 1 | Block idle, request can be taken |
| cfg_thresh | input | 8 | Detection threshold |
| cfg_gain | input | 2 | Gain value 1..3 (0 treated as 1) |
| cfg_filter | input | 2 | Filter type 0..3 |
| sclk | output | 1 | Serial link clock |
| sdat_o | output | 1 | Serial data toward sensor |
| sdat_oe | output | 1 | Drive enable for the data line |
| sdat_i | input | 1 | Serial data from sensor |
| rd_image | output | 48 | Image read back, bit 0 zeroed |
| cfg_done | output | 1 | Success pulse |
| cfg_mismatch | output | 1 | Readback differs pulse |
| cfg_timeout | output | 1 | Budget overrun pulse |

## Verification
The assertions assume three things about the inputs. The settings fields only need to be valid in the cycle a request is accepted. `sdat_i` matters only during the read high phases. `cfg_valid` may be raised or dropped at any time, so nothing is assumed about a source holding its request. The bench's sensor model changes `sdat_i` only right after a read clock rise, which leaves it settled for the whole high phase. It drives a one on the dummy bit so that the forced zero is observable. In the busy-time request test, the settings fields are changed while a request is raised against a low `cfg_ready`; the completed image and an idle link afterwards show that the request was dropped.

// File: rtl/sensor_cfg_pkg.sv
package sensor_cfg_pkg;
  localparam int IMG_W    = 48;
  localparam int TRAIL_W  = 5;
  localparam int THR_LSB  = 10;
  localparam int GAIN_LSB = 19;
  localparam int FILT_LSB = 21;
  localparam logic [TRAIL_W-1:0] TRAILER = 5'h16; // sent LSB first: 0,1,1,0,1

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_WLO, ST_WHI, ST_GAP, ST_RLO, ST_RHI, ST_TAIL
  } phase_e;

  function automatic logic [1:0] gain_code(input logic [1:0] g);
    case (g)
      2'd2:    return 2'd3;
      2'd3:    return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [2:0] filt_code(input logic [1:0] f);
    case (f)
      2'd0:    return 3'd7;
      2'd1:    return 3'd0;
      2'd2:    return 3'd1;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/sensor_cfg_pack.sv
module sensor_cfg_pack
  import sensor_cfg_pkg::*;
(
  input  logic [7:0]       thresh,
  input  logic [1:0]       gain,
  input  logic [1:0]       filter,
  output logic [IMG_W-1:0] image
);
  always_comb begin
    image = '0;
    image[THR_LSB +: 8]  = thresh;
    image[GAIN_LSB +: 2] = gain_code(gain);
    image[FILT_LSB +: 3] = filt_code(filter);
  end
endmodule

// File: rtl/sensor_cfg_timer.sv
module sensor_cfg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sensor_cfg_budget.sv
module sensor_cfg_budget #(
  parameter int          W     = 21,
  parameter logic [W-1:0] LIMIT = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic over
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign over = run && !clear && (cnt == LIMIT - 1'b1);
endmodule

// File: rtl/sensor_cfg_engine.sv
module sensor_cfg_engine
  import sensor_cfg_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int BUDGET_MS = 1400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [7:0]       cfg_thresh,
  input  logic [1:0]       cfg_gain,
  input  logic [1:0]       cfg_filter,
  output logic             sclk,
  output logic             sdat_o,
  output logic             sdat_oe,
  input  logic             sdat_i,
  output logic [IMG_W-1:0] rd_image,
  output logic             cfg_done,
  output logic             cfg_mismatch,
  output logic             cfg_timeout
);
  localparam longint HALF_RAW = longint'(CLK_HZ) / 2000;
  localparam longint LEAD_RAW = longint'(CLK_HZ) / 100000;
  localparam longint GAP_RAW  = longint'(CLK_HZ) * 30 / 1000;
  localparam longint BUD_RAW  = longint'(CLK_HZ) * BUDGET_MS / 1000;
  localparam longint HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam longint LEAD     = (LEAD_RAW < 1) ? 1 : LEAD_RAW;
  localparam longint GAP      = (GAP_RAW  < 1) ? 1 : GAP_RAW;
  localparam longint BUDGET   = (BUD_RAW  < 2) ? 2 : BUD_RAW;
  localparam longint TMAX_A   = (HALF > LEAD) ? HALF : LEAD;
  localparam longint TMAX     = (GAP > TMAX_A) ? GAP : TMAX_A;
  localparam int     TW       = $clog2(TMAX + 1);
  localparam int     BW       = $clog2(BUDGET + 1);
  localparam int     TX_W     = IMG_W - 1 + TRAIL_W;
  localparam int     CW       = $clog2(TX_W + 1);

  phase_e            state;
  logic [TX_W-1:0]   tx_sr;
  logic [IMG_W-1:0]  rx_sr, exp_img, packed_img;
  logic [CW-1:0]     bit_cnt;
  logic              tmr_load, tmr_exp, over, accept;
  logic [TW-1:0]     tmr_val;
  logic              wr_last, rd_last;

  assign accept  = (state == ST_IDLE) && cfg_valid;
  assign wr_last = (bit_cnt == CW'(TX_W - 1));
  assign rd_last = (bit_cnt == CW'(IMG_W - 1));

  sensor_cfg_pack u_pack (
    .thresh(cfg_thresh), .gain(cfg_gain), .filter(cfg_filter), .image(packed_img)
  );

  sensor_cfg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  sensor_cfg_budget #(.W(BW), .LIMIT(BW'(BUDGET))) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(state != ST_IDLE), .over(over)
  );

  // timer reload for the phase about to be entered
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (cfg_valid) begin tmr_load = 1'b1; tmr_val = TW'(LEAD - 1); end
      ST_LEAD, ST_WLO, ST_GAP, ST_RLO:
        if (tmr_exp) begin tmr_load = 1'b1; tmr_val = TW'(HALF - 1); end
      ST_WHI:
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = wr_last ? TW'(GAP - 1) : TW'(HALF - 1);
        end
      ST_RHI:
        if (tmr_exp) begin
          tmr_load = 1'b1;
          tmr_val  = rd_last ? TW'(GAP - 1) : TW'(HALF - 1);
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      tx_sr        <= '0;
      rx_sr        <= '0;
      exp_img      <= '0;
      bit_cnt      <= '0;
      cfg_done     <= 1'b0;
      cfg_mismatch <= 1'b0;
      cfg_timeout  <= 1'b0;
    end else begin
      cfg_done     <= 1'b0;
      cfg_mismatch <= 1'b0;
      cfg_timeout  <= 1'b0;
      if (over) begin
        state       <= ST_IDLE;
        bit_cnt     <= '0;
        cfg_timeout <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (cfg_valid) begin
            exp_img <= packed_img;
            bit_cnt <= '0;
            state   <= ST_LEAD;
          end
          ST_LEAD: if (tmr_exp) begin
            tx_sr <= {TRAILER, exp_img[IMG_W-1:1]};
            state <= ST_WLO;
          end
          ST_WLO: if (tmr_exp) state <= ST_WHI;
          ST_WHI: if (tmr_exp) begin
            tx_sr <= tx_sr >> 1;
            if (wr_last) begin
              bit_cnt <= '0;
              state   <= ST_GAP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              state   <= ST_WLO;
            end
          end
          ST_GAP: if (tmr_exp) state <= ST_RLO;
          ST_RLO: if (tmr_exp) state <= ST_RHI;
          ST_RHI: if (tmr_exp) begin
            if (rd_last) begin
              rx_sr   <= {sdat_i, rx_sr[IMG_W-1:2], 1'b0};
              bit_cnt <= '0;
              state   <= ST_TAIL;
            end else begin
              rx_sr   <= {sdat_i, rx_sr[IMG_W-1:1]};
              bit_cnt <= bit_cnt + 1'b1;
              state   <= ST_RLO;
            end
          end
          ST_TAIL: if (tmr_exp) begin
            state <= ST_IDLE;
            if (rx_sr == exp_img) cfg_done     <= 1'b1;
            else                  cfg_mismatch <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign cfg_ready = (state == ST_IDLE);
  assign sclk      = (state == ST_WHI) || (state == ST_RHI);
  assign sdat_oe   = (state == ST_WLO) || (state == ST_WHI);
  assign sdat_o    = sdat_oe && tx_sr[0];
  assign rd_image  = rx_sr;
endmodule

// File: rtl/sensor_cfg_engine_chk.sv
module sensor_cfg_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic        sclk,
  input logic        sdat_o,
  input logic        sdat_oe,
  input logic [47:0] rd_image,
  input logic        cfg_done,
  input logic        cfg_mismatch,
  input logic        cfg_timeout
);
  assert_clk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> !sclk);

  assert_data_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && sdat_oe) |-> $stable(sdat_o));

  assert_dummy_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done || cfg_mismatch) |-> !rd_image[0]);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done || cfg_mismatch) |=> !(cfg_done || cfg_mismatch));

  assert_release_on_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_timeout |-> (cfg_ready && !sdat_oe && !sclk));

  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_done, cfg_mismatch, cfg_timeout}));

  assert_accept_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_ready) |-> $past(cfg_valid));
endmodule

bind sensor_cfg_engine sensor_cfg_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .sclk(sclk), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .rd_image(rd_image),
  .cfg_done(cfg_done), .cfg_mismatch(cfg_mismatch), .cfg_timeout(cfg_timeout)
);

// File: tb/sensor_cfg_engine_tb.sv
module sensor_cfg_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIM_HZ     = 20000;
  localparam int HALF       = 10;
  localparam int LEAD       = 1;
  localparam int GAP        = 600;
  localparam int TMO_MS     = 100;
  localparam int TMO_CYC    = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        cfg_valid = 1'b0, cfg_ready;
  logic [7:0]  cfg_thresh = '0;
  logic [1:0]  cfg_gain = '0, cfg_filter = '0;
  logic        sclk, sdat_o, sdat_oe, sdat_i = 1'b0;
  logic [47:0] rd_image;
  logic        cfg_done, cfg_mismatch, cfg_timeout;

  logic        t_valid = 1'b0, t_ready, t_sclk, t_do, t_oe, t_done, t_mm, t_to;
  logic [47:0] t_img;

  sensor_cfg_engine #(.CLK_HZ(SIM_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_thresh(cfg_thresh), .cfg_gain(cfg_gain), .cfg_filter(cfg_filter),
    .sclk(sclk), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i),
    .rd_image(rd_image), .cfg_done(cfg_done), .cfg_mismatch(cfg_mismatch),
    .cfg_timeout(cfg_timeout));

  sensor_cfg_engine #(.CLK_HZ(SIM_HZ), .BUDGET_MS(TMO_MS)) u_dut_tmo (
    .clk(clk), .rst_n(rst_n), .cfg_valid(t_valid), .cfg_ready(t_ready),
    .cfg_thresh(8'h3C), .cfg_gain(2'd1), .cfg_filter(2'd2),
    .sclk(t_sclk), .sdat_o(t_do), .sdat_oe(t_oe), .sdat_i(1'b0),
    .rd_image(t_img), .cfg_done(t_done), .cfg_mismatch(t_mm), .cfg_timeout(t_to));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc >= 190000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    summary();
  end

  // sensor model
  logic [51:0] wbits;
  int wcnt = 0, rcnt = 0, flip_idx = -1;
  int w_rise0 = 0, w_rise1 = 0, w_fall0 = 0, w_fall_last = 0, r_rise0 = 0, r_fall_last = 0;
  bit prev_sclk = 0, last_was_wr = 0;

  always @(negedge clk) begin
    if (sclk && !prev_sclk) begin
      if (sdat_oe) begin
        if (wcnt == 0) w_rise0 = cyc;
        if (wcnt == 1) w_rise1 = cyc;
        if (wcnt < 52) wbits[wcnt] = sdat_o;
        wcnt++;
        last_was_wr = 1;
      end else begin
        if (rcnt == 0) r_rise0 = cyc;
        if (rcnt == 0)      sdat_i = 1'b1;
        else if (rcnt < 48) sdat_i = wbits[rcnt-1] ^ (rcnt == flip_idx);
        rcnt++;
        last_was_wr = 0;
      end
    end
    if (!sclk && prev_sclk) begin
      if (last_was_wr) begin
        if (wcnt == 1) w_fall0 = cyc;
        w_fall_last = cyc;
      end else r_fall_last = cyc;
    end
    prev_sclk = sclk;
  end

  function automatic logic [47:0] exp_img(input logic [7:0] t, input logic [1:0] g, input logic [1:0] f);
    logic [1:0] gc;
    logic [2:0] fc;
    gc = (g == 2) ? 2'd3 : (g == 3) ? 2'd0 : 2'd1;
    fc = (f == 0) ? 3'd7 : 3'(f - 1);
    return (48'(t) << 10) | (48'(gc) << 19) | (48'(fc) << 21);
  endfunction

  int acc = 0;

  task automatic start_op(input logic [7:0] t, input logic [1:0] g, input logic [1:0] f);
    @(negedge clk);
    for (int i = 0; i < 20 && !cfg_ready; i++) @(negedge clk);
    wcnt = 0; rcnt = 0;
    cfg_thresh = t; cfg_gain = g; cfg_filter = f; cfg_valid = 1'b1;
    acc = cyc + 1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic finish_op(input logic [7:0] t, input logic [1:0] g, input logic [1:0] f, input int flip);
    logic [47:0] e, got_w;
    logic [47:0] e_rd;
    bit d, m, o;
    int res_cyc;
    e = exp_img(t, g, f);
    for (int i = 0; i < 5000 && !(cfg_done || cfg_mismatch || cfg_timeout); i++) @(negedge clk);
    d = cfg_done; m = cfg_mismatch; o = cfg_timeout; res_cyc = cyc;
    got_w = '0;
    for (int i = 0; i < 47; i++) got_w[i+1] = wbits[i];
    chk(got_w == e, "R1 R2 written image", got_w, e);
    chk(wcnt == 52, "R4 write bit count", wcnt, 52);
    chk(wbits[51:47] == 5'b10110, "R4 end marker", wbits[51:47], 5'b10110);
    chk(rcnt == 48, "R5 read bit count", rcnt, 48);
    e_rd = (flip > 0) ? (e ^ (48'd1 << flip)) : e;
    chk(rd_image == e_rd, "R5 read image", rd_image, e_rd);
    chk(d == (flip <= 0) && m == (flip > 0) && !o, "R7 result", {d, m, o}, {flip <= 0, flip > 0, 1'b0});
    chk(w_rise0 - acc == LEAD + HALF, "R6 lead-in", w_rise0 - acc, LEAD + HALF);
    chk(w_fall0 - w_rise0 == HALF && w_rise1 - w_rise0 == 2*HALF, "R3 bit timing",
        {w_fall0 - w_rise0, w_rise1 - w_rise0}, {HALF, 2*HALF});
    chk(r_rise0 - w_fall_last == GAP + HALF, "R6 write pause", r_rise0 - w_fall_last, GAP + HALF);
    chk(res_cyc - r_fall_last == GAP, "R6 read pause", res_cyc - r_fall_last, GAP);
    @(negedge clk);
    chk(!cfg_done && !cfg_mismatch && cfg_ready && !sclk, "R9 one-cycle pulse, idle",
        {cfg_done, cfg_mismatch, cfg_ready, sclk}, 4'b0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_ready && !sclk && !sdat_oe && !cfg_done && !cfg_mismatch && !cfg_timeout,
        "R3 R9 reset state", {cfg_ready, sclk, sdat_oe}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep of all gain and filter selections with varied thresholds
    for (int k = 0; k < 16; k++) begin
      logic [7:0] th;
      th = 8'(8'hA5 ^ (k * 37));
      start_op(th, 2'(k % 4), 2'(k / 4));
      finish_op(th, 2'(k % 4), 2'(k / 4), -1);
    end
    start_op(8'h00, 2'd1, 2'd0); finish_op(8'h00, 2'd1, 2'd0, -1);
    start_op(8'hFF, 2'd3, 2'd3); finish_op(8'hFF, 2'd3, 2'd3, -1);
    // R7 mismatch: sensor returns bit 20 inverted
    flip_idx = 20;
    start_op(8'h38, 2'd2, 2'd1); finish_op(8'h38, 2'd2, 2'd1, 20);
    flip_idx = 47;
    start_op(8'h11, 2'd1, 2'd2); finish_op(8'h11, 2'd1, 2'd2, 47);
    flip_idx = -1;
    // R9: request raised while busy is not taken
    start_op(8'h5A, 2'd2, 2'd3);
    repeat (100) @(negedge clk);
    cfg_thresh = 8'hC3; cfg_gain = 2'd3; cfg_filter = 2'd0; cfg_valid = 1'b1;
    chk(!cfg_ready, "R9 ready low while busy", cfg_ready, 0);
    repeat (3) @(negedge clk);
    cfg_valid = 1'b0;
    finish_op(8'h5A, 2'd2, 2'd3, -1);
    repeat (50) @(negedge clk);
    chk(cfg_ready && wcnt == 52 && rcnt == 48, "R9 busy request dropped",
        {cfg_ready, 8'(wcnt)}, {1'b1, 8'd52});
    // R8 budget overrun on the short-budget instance
    begin
      int tacc, tcyc;
      t_valid = 1'b1; tacc = cyc + 1;
      @(negedge clk); t_valid = 1'b0;
      for (int i = 0; i < 5000 && !(t_to || t_done || t_mm); i++) @(negedge clk);
      tcyc = cyc;
      chk(t_to && !t_done && !t_mm, "R8 timeout flag", {t_to, t_done, t_mm}, 3'b100);
      chk(tcyc - tacc == TMO_CYC, "R8 timeout cycle", tcyc - tacc, TMO_CYC);
      chk(t_ready && !t_sclk && !t_oe, "R8 pins released", {t_ready, t_sclk, t_oe}, 3'b100);
      @(negedge clk);
      chk(!t_to && t_ready, "R9 timeout pulse one cycle", {t_to, t_ready}, 2'b01);
    end
    summary();
  end
endmodule